// File: doc/BRIEF.md
# Synchronous Transfer Offset Tracker

This block follows a SCSI initiator's synchronous data transfers. In synchronous mode a target may send a number of REQ pulses before the matching ACKs come back. The largest such lead is a negotiated offset. The block keeps that outstanding lead in an offset counter and keeps the remaining byte count of the current command. From these it decides when a synchronous Data-In or Data-Out transfer has finished. The two directions end under different rules. Data-Out waits for both an empty FIFO and a zero count. Data-In ends at a zero count even when received bytes are still waiting in the FIFO, because its count falls as bytes are read out of the FIFO, not as they arrive.

The block also handles the bus moving into a synchronous data phase from a non-data phase. It drops the running command and holds off the DMA path until software starts a new command. On entry into Data-In it also records how many non-data bytes were left in the FIFO and requests that they be flushed. A parity error seen on incoming data during that held-off time is not reported at once. It is kept pending and raised, together with an attention request, when the next command starts.

Phase codes on `phase`: 3'b000 is Data-Out, 3'b001 is Data-In, and every other value is a non-data phase. An offset limit of zero selects asynchronous mode.

Top module: `sync_offset_tracker`

## Requirements
- R1: After reset, all outputs are zero: `xferDone`, `offsetErr`, `offsetCount`, `nonDataCount`, `fifoFlush`, `dmaBlock`, `parityFlag` and `atnReq`.
- R2: A `cmdStart` cycle loads `cmdCount` as the remaining count. On the next edge it clears `xferDone`, `offsetErr`, `offsetCount`, `nonDataCount` and `dmaBlock`, and it makes the command active.
- R3: The offset count tracks only in synchronous mode (limit not zero), in a data phase (code 000 or 001), and while `dmaBlock` is low. In that case a REQ alone adds one and an ACK alone subtracts one. REQ and ACK together leave the count unchanged, and an ACK at zero is ignored.
- R4: A REQ without an ACK while the offset count equals `offsetLimit` sets `offsetErr` and leaves the count unchanged. `offsetErr` then stays set until the next `cmdStart`.
- R5: In Data-Out (000) each `fifoPush` of an active command decrements the remaining count. `xferDone` rises one edge after a cycle in which the count is zero and `fifoLevel` is zero, whatever the offset count is.
- R6: In Data-In (001) the remaining count decrements on `fifoPop` and not on `fifoPush`. `xferDone` rises one edge after a cycle in which the count is zero, even if `fifoLevel` is not zero.
- R7: In synchronous mode, a change from a non-data phase to code 000 or 001 ends the active command. `dmaBlock` then stays high until the next `cmdStart`, and no count decrement happens while it is high.
- R8: On entry into Data-In (001) from a non-data phase, `fifoLevel` is latched into `nonDataCount` and held until the next `cmdStart`. `fifoFlush` gives a one-cycle pulse on the edge after entry.
- R9: A `parityErrIn` seen while `dmaBlock` is high in Data-In changes no output at once. On the edge after the next `cmdStart`, `parityFlag` and `atnReq` rise, and they stay high until the `cmdStart` after that.
- R10: With `offsetLimit` at zero, phase entry has no effect, the offset count stays zero and `xferDone` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | A new transfer command begins this cycle |
| cmdCount | input | CNT_W | Byte count loaded by `cmdStart` |
| phase | input | 3 | Current bus phase code |
| offsetLimit | input | OFF_W | Negotiated offset; zero selects asynchronous mode |
| reqPulse | input | 1 | One REQ pulse received from the target |
| ackPulse | input | 1 | One ACK pulse sent to the target |
| fifoPush | input | 1 | A byte was written into the FIFO |
| fifoPop | input | 1 | A byte was read from the FIFO |
| fifoLevel | input | FIFO_W | Current FIFO occupancy |
| parityErrIn | input | 1 | Parity error on an incoming byte |
| xferDone | output | 1 | Synchronous transfer completed |
| offsetErr | output | 1 | Sticky: target exceeded the offset limit |
| offsetCount | output | OFF_W | Outstanding REQs not yet answered by an ACK |
| nonDataCount | output | FIFO_W | Latched number of non-data bytes flushed on Data-In entry |
| fifoFlush | output | 1 | One-cycle request to flush the FIFO |
| dmaBlock | output | 1 | DMA path held off after phase entry |
| parityFlag | output | 1 | Deferred parity error flag |
| atnReq | output | 1 | Attention request raised with the deferred parity error |

## Verification
The assertions assume that `offsetLimit` stays constant within a command. They also assume `fifoLevel` is a plain occupancy value that may change freely between cycles. The checks that `xferDone` only follows a zero count and, in Data-Out, an empty FIFO rely on the phase being steady across the completing cycle. The stimulus changes the limit and the phase only between commands or at deliberate phase-entry points. It drives `fifoLevel` directly as a level, and it keeps REQ/ACK sequences on the bus side that a real target could produce, apart from one deliberate overrun of the offset.

// File: rtl/sot_pkg.sv
package sot_pkg;
  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;
  localparam logic [2:0] PH_MIN  = 3'b111;

  typedef struct packed {
    logic load;      // command start
    logic latchIn;   // Data-In entry: capture leftover count
    logic decCount;  // decrement remaining byte count
    logic trackEn;   // offset counter may move
  } strobe_t;

  function automatic logic isDataPhase(input logic [2:0] p);
    return (p == PH_DOUT) || (p == PH_DIN);
  endfunction
endpackage

// File: rtl/sot_ctrl.sv
module sot_ctrl
  import sot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [2:0] phase,
  input  logic       syncMode,
  input  logic       fifoPush,
  input  logic       fifoPop,
  input  logic       fifoEmpty,
  input  logic       countZero,
  input  logic       parityErrIn,
  output strobe_t    strb,
  output logic       xferDone,
  output logic       dmaBlock,
  output logic       fifoFlush,
  output logic       parityFlag,
  output logic       atnReq
);
  logic [2:0] prevPhase;
  logic       active;
  logic       pendPar;
  logic       entry;
  logic       doneCond;

  always_comb begin
    entry         = syncMode && isDataPhase(phase) && !isDataPhase(prevPhase);
    strb.load     = cmdStart;
    strb.latchIn  = entry && (phase == PH_DIN);
    strb.decCount = active && !cmdStart &&
                    (((phase == PH_DOUT) && fifoPush) || ((phase == PH_DIN) && fifoPop));
    strb.trackEn  = syncMode && isDataPhase(phase) && !dmaBlock;
    doneCond      = active && syncMode && !cmdStart && !entry && countZero &&
                    ((phase == PH_DIN) || ((phase == PH_DOUT) && fifoEmpty));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase  <= PH_MIN;
      active     <= 1'b0;
      dmaBlock   <= 1'b0;
      xferDone   <= 1'b0;
      fifoFlush  <= 1'b0;
      pendPar    <= 1'b0;
      parityFlag <= 1'b0;
      atnReq     <= 1'b0;
    end else begin
      prevPhase <= phase;
      fifoFlush <= strb.latchIn;
      if (cmdStart) begin
        active     <= 1'b1;
        dmaBlock   <= 1'b0;
        xferDone   <= 1'b0;
        parityFlag <= pendPar;
        atnReq     <= pendPar;
        pendPar    <= 1'b0;
      end else begin
        if (entry) begin
          active   <= 1'b0;
          dmaBlock <= 1'b1;
        end else if (doneCond) begin
          active   <= 1'b0;
          xferDone <= 1'b1;
        end
        if (dmaBlock && (phase == PH_DIN) && parityErrIn)
          pendPar <= 1'b1;
      end
    end
  end

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> $past(countZero)); // R5
  AST_DOUT_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferDone) && ($past(phase) == PH_DOUT)) |-> $past(fifoEmpty)); // R5
  AST_BLOCK_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    dmaBlock |-> !strb.decCount); // R7
  AST_PARITY_AT_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityFlag) |-> $past(cmdStart)); // R9
endmodule

// File: rtl/sot_datapath.sv
module sot_datapath
  import sot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 4,
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [OFF_W-1:0]  offsetLimit,
  input  logic              reqPulse,
  input  logic              ackPulse,
  input  logic [FIFO_W-1:0] fifoLevel,
  output logic              countZero,
  output logic [OFF_W-1:0]  offsetCount,
  output logic              offsetErr,
  output logic [FIFO_W-1:0] nonDataCount
);
  localparam logic [OFF_W-1:0] ONE_OFF = OFF_W'(1);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0] remaining;
  logic             overrun;
  logic             incOff;
  logic             decOff;

  always_comb begin
    countZero = (remaining == '0);
    overrun   = strb.trackEn && reqPulse && !ackPulse && (offsetCount == offsetLimit);
    incOff    = strb.trackEn && reqPulse && !ackPulse && !overrun;
    decOff    = strb.trackEn && ackPulse && !reqPulse && (offsetCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining    <= '0;
      offsetCount  <= '0;
      offsetErr    <= 1'b0;
      nonDataCount <= '0;
    end else if (strb.load) begin
      remaining    <= cmdCount;
      offsetCount  <= '0;
      offsetErr    <= 1'b0;
      nonDataCount <= '0;
    end else begin
      if (strb.decCount && !countZero) remaining <= remaining - ONE_CNT;
      if (incOff)      offsetCount <= offsetCount + ONE_OFF;
      else if (decOff) offsetCount <= offsetCount - ONE_OFF;
      if (overrun) offsetErr <= 1'b1;
      if (strb.latchIn) nonDataCount <= fifoLevel;
    end
  end

  AST_OFFSET_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (offsetErr && !strb.load) |=> offsetErr); // R4
  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && strb.trackEn && reqPulse && !ackPulse && (offsetCount == offsetLimit))
      |=> (offsetErr && $stable(offsetCount))); // R4
  AST_NONDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.latchIn) |=> $stable(nonDataCount)); // R8
endmodule

// File: rtl/sync_offset_tracker.sv
module sync_offset_tracker
  import sot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 4,
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [2:0]        phase,
  input  logic [OFF_W-1:0]  offsetLimit,
  input  logic              reqPulse,
  input  logic              ackPulse,
  input  logic              fifoPush,
  input  logic              fifoPop,
  input  logic [FIFO_W-1:0] fifoLevel,
  input  logic              parityErrIn,
  output logic              xferDone,
  output logic              offsetErr,
  output logic [OFF_W-1:0]  offsetCount,
  output logic [FIFO_W-1:0] nonDataCount,
  output logic              fifoFlush,
  output logic              dmaBlock,
  output logic              parityFlag,
  output logic              atnReq
);
  strobe_t strb;
  logic    countZero;
  logic    syncMode;
  logic    fifoEmpty;

  assign syncMode  = (offsetLimit != '0);
  assign fifoEmpty = (fifoLevel == '0);

  sot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .phase(phase),
    .syncMode(syncMode), .fifoPush(fifoPush), .fifoPop(fifoPop),
    .fifoEmpty(fifoEmpty), .countZero(countZero), .parityErrIn(parityErrIn),
    .strb(strb), .xferDone(xferDone), .dmaBlock(dmaBlock),
    .fifoFlush(fifoFlush), .parityFlag(parityFlag), .atnReq(atnReq)
  );

  sot_datapath #(.CNT_W(CNT_W), .OFF_W(OFF_W), .FIFO_W(FIFO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdCount(cmdCount),
    .offsetLimit(offsetLimit), .reqPulse(reqPulse), .ackPulse(ackPulse),
    .fifoLevel(fifoLevel), .countZero(countZero), .offsetCount(offsetCount),
    .offsetErr(offsetErr), .nonDataCount(nonDataCount)
  );
endmodule

// File: tb/sim_sync_offset_tracker.sv
`timescale 1ns/1ps
module sim_sync_offset_tracker;
  localparam int CNT_W = 16, OFF_W = 4, FIFO_W = 5;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, reqPulse = 0, ackPulse = 0, fifoPush = 0, fifoPop = 0, parityErrIn = 0;
  logic [CNT_W-1:0]  cmdCount = '0;
  logic [2:0]        phase = 3'b111;
  logic [OFF_W-1:0]  offsetLimit = 4'd4;
  logic [FIFO_W-1:0] fifoLevel = '0;
  logic xferDone, offsetErr, fifoFlush, dmaBlock, parityFlag, atnReq;
  logic [OFF_W-1:0]  offsetCount;
  logic [FIFO_W-1:0] nonDataCount;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_offset_tracker #(.CNT_W(CNT_W), .OFF_W(OFF_W), .FIFO_W(FIFO_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdCount(cmdCount), .phase(phase),
    .offsetLimit(offsetLimit), .reqPulse(reqPulse), .ackPulse(ackPulse),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoLevel(fifoLevel),
    .parityErrIn(parityErrIn), .xferDone(xferDone), .offsetErr(offsetErr),
    .offsetCount(offsetCount), .nonDataCount(nonDataCount), .fifoFlush(fifoFlush),
    .dmaBlock(dmaBlock), .parityFlag(parityFlag), .atnReq(atnReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FIFO-check FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mThr = 0, mCnt = 0, mNd = 0, mPrev = 7;
  bit mDone = 0, mErr = 0, mBlk = 0, mAct = 0, mPend = 0, mPar = 0, mAtn = 0, mFl = 0;

  function automatic bit isData(input int p);
    return (p == 0) || (p == 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = 0; mCnt = 0; mNd = 0; mPrev = 7;
      mDone = 0; mErr = 0; mBlk = 0; mAct = 0; mPend = 0; mPar = 0; mAtn = 0; mFl = 0;
    end else begin
      int ph;
      bit sync, ent, dec, trk, fin;
      ph   = int'(phase);
      sync = (offsetLimit != 0);
      ent  = sync && isData(ph) && !isData(mPrev);
      dec  = mAct && !cmdStart && ((ph == 0 && fifoPush) || (ph == 1 && fifoPop));
      trk  = sync && isData(ph) && !mBlk;
      fin  = mAct && sync && !cmdStart && !ent && (mCnt == 0) &&
             ((ph == 1) || (ph == 0 && fifoLevel == 0));
      mFl  = ent && (ph == 1);
      if (cmdStart) begin
        mCnt = int'(cmdCount); mThr = 0; mErr = 0; mNd = 0;
        mAct = 1; mBlk = 0; mDone = 0; mPar = mPend; mAtn = mPend; mPend = 0;
      end else begin
        if (dec && mCnt > 0) mCnt--;
        if (trk && reqPulse && !ackPulse) begin
          if (mThr == int'(offsetLimit)) mErr = 1; else mThr++;
        end else if (trk && ackPulse && !reqPulse && mThr > 0) mThr--;
        if (ent && ph == 1) mNd = int'(fifoLevel);
        if (mBlk && ph == 1 && parityErrIn) mPend = 1;
        if (ent) begin mAct = 0; mBlk = 1; end
        else if (fin) begin mAct = 0; mDone = 1; end
      end
      mPrev = ph;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R5 R6 xferDone", int'(xferDone), int'(mDone));
      chk("R4 offsetErr", int'(offsetErr), int'(mErr));
      chk("R3 offsetCount", int'(offsetCount), mThr);
      chk("R8 nonDataCount", int'(nonDataCount), mNd);
      chk("R8 fifoFlush", int'(fifoFlush), int'(mFl));
      chk("R7 dmaBlock", int'(dmaBlock), int'(mBlk));
      chk("R9 parityFlag", int'(parityFlag), int'(mPar));
      chk("R9 atnReq", int'(atnReq), int'(mAtn));
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic startCmd(input int cnt);
    cmdStart = 1; cmdCount = CNT_W'(cnt); cyc(); cmdStart = 0;
  endtask

  initial begin
    #(4 * 200000);
    nFail++; nChecks++;
    $display("Watchdog FAIL timeout actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    cyc(2);
    // R1: reset values
    chk("R1 outputs", int'({xferDone, offsetErr, fifoFlush, dmaBlock, parityFlag, atnReq}), 0);
    chk("R1 counts", int'(offsetCount) + int'(nonDataCount), 0);
    rstN = 1; cyc(2);

    // entry into Data-In with 3 leftover non-data bytes
    fifoLevel = 5'd3; phase = 3'b001; cyc();
    chk("R8 flush pulse", int'(fifoFlush), 1);
    chk("R8 latched count", int'(nonDataCount), 3);
    chk("R7 blocked", int'(dmaBlock), 1);
    fifoLevel = 0; parityErrIn = 1; fifoPop = 1; reqPulse = 1; cyc(); parityErrIn = 0; fifoPop = 0; reqPulse = 0;
    chk("R9 not reported yet", int'(parityFlag), 0);
    chk("R7 no tracking while blocked", int'(offsetCount), 0);
    chk("R8 flush single", int'(fifoFlush), 0);
    chk("R8 held", int'(nonDataCount), 3);
    cyc(2);
    startCmd(5);
    chk("R9 parity flag", int'(parityFlag), 1);
    chk("R9 atn", int'(atnReq), 1);
    chk("R2 unblocked", int'(dmaBlock), 0);
    chk("R2 nondata cleared", int'(nonDataCount), 0);

    // Data-In: REQs push bytes, count only moves on pops
    reqPulse = 1; fifoPush = 1; cyc(3); reqPulse = 0; fifoPush = 0;
    chk("R3 three outstanding", int'(offsetCount), 3);
    reqPulse = 1; ackPulse = 1; cyc(); reqPulse = 0;
    chk("R3 req with ack", int'(offsetCount), 3);
    cyc(3); ackPulse = 0;
    chk("R3 drained", int'(offsetCount), 0);
    ackPulse = 1; cyc(); ackPulse = 0;
    chk("R3 ack at zero", int'(offsetCount), 0);
    fifoLevel = 5'd4; fifoPop = 1; cyc(5); fifoPop = 0;
    chk("R6 not yet done", int'(xferDone), 0);
    cyc();
    chk("R6 done with bytes left", int'(xferDone), 1);
    cyc(2);

    // Data-Out: needs empty FIFO and zero count
    phase = 3'b000; fifoLevel = 5'd2;
    startCmd(3);
    chk("R2 done cleared", int'(xferDone), 0);
    chk("R9 parity cleared", int'(parityFlag), 0);
    fifoPush = 1; reqPulse = 1; cyc(2); reqPulse = 0; ackPulse = 1; cyc(); ackPulse = 0; fifoPush = 0;
    cyc(2);
    chk("R5 waits for empty FIFO", int'(xferDone), 0);
    fifoLevel = 0; cyc(2);
    chk("R5 done", int'(xferDone), 1);
    chk("R5 offset not zero", int'(offsetCount), 1);

    // offset overrun
    startCmd(10);
    reqPulse = 1; cyc(4);
    chk("R4 at limit", int'(offsetErr), 0);
    ackPulse = 1; cyc(); ackPulse = 0;
    chk("R4 req+ack at limit", int'(offsetErr), 0);
    cyc(); reqPulse = 0;
    chk("R4 overrun flagged", int'(offsetErr), 1);
    chk("R4 count held", int'(offsetCount), 4);
    ackPulse = 1; cyc(2); ackPulse = 0;
    chk("R4 sticky", int'(offsetErr), 1);
    startCmd(10);
    chk("R2 err cleared", int'(offsetErr), 0);
    chk("R2 offset cleared", int'(offsetCount), 0);

    // asynchronous mode
    offsetLimit = 0; phase = 3'b111; cyc(2);
    fifoLevel = 5'd3; phase = 3'b001; cyc();
    chk("R10 no block", int'(dmaBlock), 0);
    chk("R10 no latch", int'(nonDataCount), 0);
    reqPulse = 1; fifoPop = 1; cyc(12); reqPulse = 0; fifoPop = 0; cyc(2);
    chk("R10 no offset", int'(offsetCount), 0);
    chk("R10 no done", int'(xferDone), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule